// File: doc/BRIEF.md
# Hit Time Tag Decoder

This block takes the snapshot captured for one timing channel and turns it into a binary time word. A snapshot has two parts. The first is a coarse count from a counter that ticks once per roughly 400 ps period. The counter is sampled twice, on the early and on the late phase of that period. The second part is a 128-bit sample of the fine delay line. That line splits each counter period into 32 taps of about 12 ps, and each tap into 4 interpolation sub-bins of about 3 ps. The 128 bits form a thermometer code. The decoder finds where the code ends and makes a 7-bit fine code from it. It uses the top fine bit to choose which counter sample is stable. It then emits the result as a leading-edge, trailing-edge or time-over-threshold word.

The block is a two-stage pipeline and accepts one snapshot per cycle. An output register with a valid/ready handshake stalls the whole pipeline when downstream stops taking words. There is a low-power mode that reports 12 ps resolution with the two sub-bin bits cleared. There is also a pairing mode. In that mode a leading edge is held back, and the next trailing edge produces the difference of the two times, wrapped modulo the coarse range. The 18-bit coarse field covers more than 100 µs.

Top module: `hit_tag_decoder`

## Requirements
- R1: After reset, word_valid_o and orphan_o are 0 and hit_ready_o is 1.
- R2: Tap bit 0 is the earliest tap. The fine code (word bits 6:0) is the index of the lowest tap bit that is 0. A snapshot with all bits set gives 127.
- R3: bubble_o is 1 alongside a word when any tap bit is 1 above a tap bit that is 0. The fine code is still the lowest zero index. A clean thermometer gives bubble_o = 0.
- R4: With interp_off_i = 1, fine bits 1:0 of the word are 0. Bits 6:2 are unchanged.
- R5: The coarse field (word bits 24:7) is taken from coarse_late_i when fine bit 6 is 0. It is taken from coarse_early_i when fine bit 6 is 1.
- R6: The word is {type[1:0], coarse[17:0], fine[6:0]}, where type 00 = leading, 01 = trailing and 10 = time over threshold. With pair_i = 0, every accepted hit yields one word, typed by edge_trail_i.
- R7: A hit accepted at a rising edge appears on word_valid_o/word_o after the next rising edge. One hit per cycle is accepted while word_ready_i is 1.
- R8: With pair_i = 1, a leading edge produces no word and becomes the pending leading time, replacing any older one. A later trailing edge emits type 10 with bits 24:0 = (trailing {coarse,fine} − pending {coarse,fine}) mod 2^25, and clears the pending time.
- R9: With pair_i = 1, a trailing edge with no pending leading time produces no word, and orphan_o is 1 for exactly the cycle in which that word would have appeared.
- R10: While word_valid_o = 1 and word_ready_i = 0, word_o stays stable, hit_ready_o is 0 and no word is lost. Held words leave in order once word_ready_i returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_valid_i | input | 1 | Snapshot present |
| hit_ready_o | output | 1 | Snapshot accepted this cycle |
| coarse_early_i | input | 18 | Counter sampled on the early phase |
| coarse_late_i | input | 18 | Counter sampled on the late phase |
| taps_i | input | 128 | Delay-line thermometer snapshot, bit 0 earliest |
| edge_trail_i | input | 1 | 0 = leading edge, 1 = trailing edge |
| interp_off_i | input | 1 | Interpolator off, 12 ps resolution |
| pair_i | input | 1 | Pair edges into time over threshold |
| word_valid_o | output | 1 | Output word valid |
| word_ready_i | input | 1 | Downstream takes the word |
| word_o | output | 27 | {type, coarse, fine} |
| bubble_o | output | 1 | Thermometer bubble seen for this word |
| orphan_o | output | 1 | Unpaired trailing edge dropped |

## Verification
The bench probes several points in the thermometer decode. Tap 0 cleared should give fine 0. A code ending at the half-period boundary, code 63 against 64, should switch the counter sample. A full snapshot should give 127. A decoder off by one tap, or one that picks the wrong counter phase, would shift every time by 12 ps or by a full 400 ps. The bench also tests a snapshot with a stray set bit, so a design that decodes the highest transition, or that never flags the bubble, would be caught. In pairing mode it checks that time over threshold wraps correctly across the top of the coarse range. It checks that a newer leading edge replaces an older one, and that a trailing edge with no partner gives no word. Last, it holds word_ready_i low with two hits in flight, which exposes an output that changes, overwrites or drops words under backpressure.

// File: rtl/htd_pkg.sv
package htd_pkg;
  localparam int COARSE_W = 18;
  localparam int FINE_W   = 7;
  localparam int TIME_W   = COARSE_W + FINE_W;
  localparam int WORD_W   = TIME_W + 2;

  typedef enum logic [1:0] {
    TAG_LEAD  = 2'b00,
    TAG_TRAIL = 2'b01,
    TAG_TOT   = 2'b10
  } tag_kind_e;
endpackage

// File: rtl/htd_therm_dec.sv
module htd_therm_dec #(
  parameter int FINE_W = 7,
  localparam int TAPS_N = 2 ** FINE_W
) (
  input  logic [TAPS_N-1:0] taps_i,
  output logic [FINE_W-1:0] fine_o,
  output logic              bubble_o
);
  // lowest zero tap; all-ones saturates at the last tap
  always_comb begin
    fine_o = FINE_W'(TAPS_N - 1);
    for (int i = TAPS_N - 1; i >= 0; i--)
      if (!taps_i[i]) fine_o = FINE_W'(i);
  end

  // a set tap above a cleared one breaks the thermometer
  assign bubble_o = |(~taps_i[TAPS_N-2:0] & taps_i[TAPS_N-1:1]);

  // R2: clean code must equal the mask implied by the decoded position
  always_comb
    if (!bubble_o && !(&taps_i))
      a_r2_clean_therm: assert (taps_i == ((TAPS_N'(1) << fine_o) - TAPS_N'(1)));
endmodule

// File: rtl/htd_pair.sv
module htd_pair
  import htd_pkg::*;
#(
  parameter int TW = TIME_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          s1_valid_i,
  input  logic          s1_trail_i,
  input  logic          s1_pair_i,
  input  logic [TW-1:0] s1_time_i,
  input  logic          s1_bubble_i,
  output logic          word_valid_o,
  output logic [TW+1:0] word_o,
  output logic          bubble_o,
  output logic          orphan_o
);
  logic          pend_q;
  logic [TW-1:0] pend_time_q;
  logic          pend_bubble_q;

  logic          emit;
  logic [TW+1:0] word_d;
  logic          bubble_d;
  logic          orphan_d;
  logic          take_lead;

  always_comb begin
    emit      = 1'b0;
    orphan_d  = 1'b0;
    take_lead = 1'b0;
    bubble_d  = s1_bubble_i;
    word_d    = {s1_trail_i ? TAG_TRAIL : TAG_LEAD, s1_time_i};
    if (s1_valid_i) begin
      if (!s1_pair_i) begin
        emit = 1'b1;
      end else if (!s1_trail_i) begin
        take_lead = 1'b1;
      end else if (pend_q) begin
        emit     = 1'b1;
        word_d   = {TAG_TOT, s1_time_i - pend_time_q};
        bubble_d = s1_bubble_i | pend_bubble_q;
      end else begin
        orphan_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q        <= 1'b0;
      pend_time_q   <= '0;
      pend_bubble_q <= 1'b0;
      word_valid_o  <= 1'b0;
      word_o        <= '0;
      bubble_o      <= 1'b0;
      orphan_o      <= 1'b0;
    end else begin
      orphan_o <= adv_i & orphan_d;
      if (adv_i) begin
        word_valid_o <= emit;
        if (emit) begin
          word_o   <= word_d;
          bubble_o <= bubble_d;
        end
        if (take_lead) begin
          pend_q        <= 1'b1;
          pend_time_q   <= s1_time_i;
          pend_bubble_q <= s1_bubble_i;
        end else if (s1_valid_i && s1_pair_i && s1_trail_i) begin
          pend_q <= 1'b0;
        end
      end
    end
  end

  a_r9_orphan_unpaired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orphan_o |-> !$past(pend_q));

  a_r6_kind_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> word_o[TW+1:TW] != 2'b11);

  a_r8_tot_needs_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_valid_o) && word_o[TW+1:TW] == TAG_TOT |-> $past(s1_pair_i));
endmodule

// File: rtl/hit_tag_decoder.sv
module hit_tag_decoder
  import htd_pkg::*;
#(
  parameter int CW = COARSE_W,
  parameter int FW = FINE_W,
  localparam int TAPS_N = 2 ** FW,
  localparam int TW     = CW + FW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_valid_i,
  output logic              hit_ready_o,
  input  logic [CW-1:0]     coarse_early_i,
  input  logic [CW-1:0]     coarse_late_i,
  input  logic [TAPS_N-1:0] taps_i,
  input  logic              edge_trail_i,
  input  logic              interp_off_i,
  input  logic              pair_i,
  output logic              word_valid_o,
  input  logic              word_ready_i,
  output logic [TW+1:0]     word_o,
  output logic              bubble_o,
  output logic              orphan_o
);
  logic          adv;
  logic [FW-1:0] fine_raw;
  logic [FW-1:0] fine_d;
  logic          bubble_raw;
  logic [CW-1:0] coarse_d;

  logic          s1_valid_q, s1_trail_q, s1_pair_q, s1_bubble_q, s1_ioff_q;
  logic [TW-1:0] s1_time_q;

  assign adv         = !word_valid_o || word_ready_i;
  assign hit_ready_o = adv;

  htd_therm_dec #(.FINE_W(FW)) u_dec (
    .taps_i   (taps_i),
    .fine_o   (fine_raw),
    .bubble_o (bubble_raw)
  );

  // sub-bin bits dropped when the interpolator is off
  assign fine_d   = interp_off_i ? {fine_raw[FW-1:2], 2'b00} : fine_raw;
  // first half of the period sits near the counter edge: use the late sample
  assign coarse_d = fine_d[FW-1] ? coarse_early_i : coarse_late_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q  <= 1'b0;
      s1_trail_q  <= 1'b0;
      s1_pair_q   <= 1'b0;
      s1_bubble_q <= 1'b0;
      s1_ioff_q   <= 1'b0;
      s1_time_q   <= '0;
    end else if (adv) begin
      s1_valid_q  <= hit_valid_i;
      s1_trail_q  <= edge_trail_i;
      s1_pair_q   <= pair_i;
      s1_bubble_q <= bubble_raw;
      s1_ioff_q   <= interp_off_i;
      s1_time_q   <= {coarse_d, fine_d};
    end
  end

  htd_pair #(.TW(TW)) u_pair (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (adv),
    .s1_valid_i   (s1_valid_q),
    .s1_trail_i   (s1_trail_q),
    .s1_pair_i    (s1_pair_q),
    .s1_time_i    (s1_time_q),
    .s1_bubble_i  (s1_bubble_q),
    .word_valid_o (word_valid_o),
    .word_o       (word_o),
    .bubble_o     (bubble_o),
    .orphan_o     (orphan_o)
  );

  a_r10_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_o));

  a_r10_no_accept_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |-> !hit_ready_o);

  a_r4_sub_bins_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_q && s1_ioff_q |-> s1_time_q[1:0] == 2'b00);

  a_r7_one_stage_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_i && hit_ready_o && !pair_i |=> s1_valid_q);
endmodule

// File: tb/hit_tag_decoder_tb_top.sv
module hit_tag_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         hit_valid = 1'b0, hit_ready;
  logic [17:0]  c_early = '0, c_late = '0;
  logic [127:0] taps = '0;
  logic         trail = 1'b0, ioff = 1'b0, pair = 1'b0;
  logic         wvalid, wready = 1'b1, bub, orph;
  logic [26:0]  word;

  int n_chk = 0, n_fail = 0;

  hit_tag_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hit_valid_i(hit_valid), .hit_ready_o(hit_ready),
    .coarse_early_i(c_early), .coarse_late_i(c_late), .taps_i(taps),
    .edge_trail_i(trail), .interp_off_i(ioff), .pair_i(pair),
    .word_valid_o(wvalid), .word_ready_i(wready), .word_o(word),
    .bubble_o(bub), .orphan_o(orph)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] therm(input int n);
    if (n >= 128) return '1;
    return (128'd1 << n) - 128'd1;
  endfunction

  // drive one hit, then check the output one cycle after acceptance
  task automatic hit(input logic [127:0] t, input logic [17:0] e, input logic [17:0] l,
                     input bit tr, input bit off, input bit pr);
    @(negedge clk);
    taps = t; c_early = e; c_late = l; trail = tr; ioff = off; pair = pr; hit_valid = 1'b1;
    @(negedge clk);
    hit_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_word(input string req, input logic [26:0] exp, input bit exp_bub);
    chk(wvalid == 1'b1, req, wvalid, 1);
    chk(word == exp, req, word, exp);
    chk(bub == exp_bub, req, bub, exp_bub);
  endtask

  task automatic t_reset;
    chk(wvalid == 1'b0, "R1", wvalid, 0);
    chk(hit_ready == 1'b1, "R1", hit_ready, 1);
    chk(orph == 1'b0, "R1", orph, 0);
  endtask

  task automatic t_decode;
    int pts[6] = '{0, 1, 63, 64, 127, 128};
    foreach (pts[k]) begin
      logic [6:0] f;
      logic [17:0] c;
      f = (pts[k] >= 128) ? 7'd127 : 7'(pts[k]);
      c = f[6] ? 18'h00100 : 18'h00200; // R5 phase selection
      hit(therm(pts[k]), 18'h00100, 18'h00200, 1'b0, 1'b0, 1'b0);
      expect_word("R2/R5/R6", {2'b00, c, f}, 1'b0);
    end
  endtask

  task automatic t_bubble;
    hit(therm(10) | (128'd1 << 50), 18'd7, 18'd9, 1'b0, 1'b0, 1'b0);
    expect_word("R3", {2'b00, 18'd9, 7'd10}, 1'b1);
    hit(therm(11), 18'd7, 18'd9, 1'b0, 1'b0, 1'b0);
    expect_word("R3 clean", {2'b00, 18'd9, 7'd11}, 1'b0);
  endtask

  task automatic t_interp_off;
    hit(therm(45), 18'd3, 18'd4, 1'b0, 1'b1, 1'b0);
    expect_word("R4", {2'b00, 18'd4, 7'd44}, 1'b0);
    hit(therm(103), 18'd3, 18'd4, 1'b1, 1'b1, 1'b0);
    expect_word("R4 R6 trailing", {2'b01, 18'd3, 7'd100}, 1'b0);
  endtask

  task automatic t_pairing;
    hit(therm(20), 18'd0, 18'd5, 1'b0, 1'b0, 1'b1);
    chk(wvalid == 1'b0, "R8 lead silent", wvalid, 0);
    hit(therm(10), 18'd0, 18'd8, 1'b1, 1'b0, 1'b1);
    expect_word("R8 tot", {2'b10, 25'd374}, 1'b0);
    // wrap across the top of the coarse range
    hit(therm(100), 18'h3FFFF, 18'd0, 1'b0, 1'b0, 1'b1);
    hit(therm(3), 18'd0, 18'd1, 1'b1, 1'b0, 1'b1);
    expect_word("R8 wrap", {2'b10, 25'd159}, 1'b0);
    // newer leading replaces older
    hit(therm(0), 18'd0, 18'd1, 1'b0, 1'b0, 1'b1);
    hit(therm(5), 18'd0, 18'd10, 1'b0, 1'b0, 1'b1);
    hit(therm(9), 18'd0, 18'd12, 1'b1, 1'b0, 1'b1);
    expect_word("R8 replace", {2'b10, 25'd260}, 1'b0);
  endtask

  task automatic t_orphan;
    hit(therm(9), 18'd0, 18'd12, 1'b1, 1'b0, 1'b1);
    chk(wvalid == 1'b0, "R9 no word", wvalid, 0);
    chk(orph == 1'b1, "R9 pulse", orph, 1);
    @(negedge clk);
    chk(orph == 1'b0, "R9 one cycle", orph, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    wready = 1'b0;
    taps = therm(30); c_late = 18'd40; trail = 1'b0; ioff = 1'b0; pair = 1'b0; hit_valid = 1'b1;
    @(negedge clk);
    taps = therm(31); c_late = 18'd41;
    @(negedge clk);
    hit_valid = 1'b0;
    chk(hit_ready == 1'b0, "R10 ready low", hit_ready, 0);
    repeat (3) @(negedge clk);
    expect_word("R10 held", {2'b00, 18'd40, 7'd30}, 1'b0);
    wready = 1'b1;
    @(negedge clk);
    expect_word("R10 second in order", {2'b00, 18'd41, 7'd31}, 1'b0);
    @(negedge clk);
    chk(wvalid == 1'b0, "R10 drained", wvalid, 0);
  endtask

  task automatic t_throughput;
    // R7: back-to-back hits, one word per cycle
    @(negedge clk);
    pair = 1'b0; ioff = 1'b0; trail = 1'b0; c_late = 18'd2; hit_valid = 1'b1; taps = therm(1);
    @(negedge clk);
    taps = therm(2);
    @(negedge clk);
    hit_valid = 1'b0;
    expect_word("R7 first", {2'b00, 18'd2, 7'd1}, 1'b0);
    @(negedge clk);
    expect_word("R7 second", {2'b00, 18'd2, 7'd2}, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_bubble();
        t_interp_off();
        t_pairing();
        t_orphan();
        t_backpressure();
        t_throughput();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule